// File: doc/BRIEF.md
# SD/MMC Command and Response Sequencer

This block is the command half of an SD/MMC host controller. Software sets it up through a small word-addressed register port. It holds a 6-bit command index, a 32-bit argument written as two 16-bit halves, a 14-bit command/data control word and the card clock run state. Writing the control word arms a command. The command goes to the card when the clock is running and the stop-transfer bit is clear. If the clock is stopped, the command waits until the clock is started.

The card side is an abstract handshake. A one-cycle `card_cmd_valid` carries the index and the argument. The card later answers with `card_resp_valid`, a byte count and up to 16 response bytes. The response-type field of the control word sets the least number of bytes that counts as a valid answer; a shorter answer is a response timeout. A valid answer is packed two bytes per entry into a nine-entry, 16-bit response FIFO. If the command also moves data, a byte counter loads with block length times block count.

The block also keeps the 13-bit interrupt pending and mask registers and drives the interrupt line. When DMA is enabled, the two data-FIFO request bits leave the interrupt path and drive separate DMA request outputs.

Top module: `sdmmc_cmd_seq`

## Requirements
- R1: Register word addresses: 0 clock control, 1 status, 2 control word, 3 block length, 4 block count, 5 interrupt mask, 6 interrupt pending, 7 command index, 8 argument high half, 9 argument low half, 10 response FIFO, 11 data byte counter. Read data appears on `reg_rdata` on the cycle after `reg_rd` is sampled. The clock control register always reads 0.
- R2: The command index keeps 6 bits. It reads back as the index with bit 6 set, so writing 0x7F reads 0x7F and writing 0x25 reads 0x65.
- R3: A write to address 8 replaces only argument bits 31:16. A write to address 9 replaces only bits 15:0.
- R4: A control-word write keeps the bits under mask 0x3DFF, cancels any active transfer and arms a command. When bit 10 (stop-transfer) is clear, the write also clears every status bit except bit 8, and the command issues at once if the clock is running. With bit 10 set, nothing issues.
- R5: An armed command issues when clock control bit 1 (start) is written, unless control bit 10 is set. While the clock is stopped, no command issues.
- R6: Control bits 1:0 select the response type: 0 needs no bytes, 1 and 3 need at least 4 bytes, and 2 needs 16 bytes. A shorter answer sets status bit 1 (response timeout) and does not set status bit 13.
- R7: Response byte 2i goes to bits 7:0 of FIFO entry i and byte 2i+1 goes to bits 15:8. Bytes past the returned count are 0. The FIFO is cleared at each issue and stays empty after a timeout. Each read of address 10 pops one entry in order. Reads after the ninth entry return 0.
- R8: Pending bit 2 (end of command) sets on every answer. Status bit 13 sets only on success. On success with control bit 2 (data enable) set, the byte counter loads block length (12 bits) times block count (16 bits) and `xfer_active` rises.
- R9: Writing clock control bit 0 (stop) clears status bit 8, sets pending bit 4 (clock off) and drops `xfer_active` and any wait for an answer. Writing bit 1 (start) sets status bit 8 and clears pending bit 4.
- R10: `irq` is high when any pending bit is set and its bit in the 13-bit mask is 0.
- R11: With control bit 7 (DMA enable) set, pending bits 5 (RX request) and 6 (TX request) do not raise `irq`. They drive `dma_rx_req` and `dma_tx_req` instead; without DMA enable, both DMA outputs are 0. `fifo_req_set` bit 0 sets pending bit 5 and bit 1 sets pending bit 6.
- R12: Writing 1 to a pending bit clears it. Reading status or pending changes nothing.
- R13: An issue produces a one-cycle `card_cmd_valid` with the current index and argument. An answer is accepted only while one is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| card_cmd_valid | output | 1 | One-cycle command issue |
| card_cmd_index | output | 6 | Command index to card |
| card_cmd_arg | output | 32 | Command argument to card |
| card_resp_valid | input | 1 | Card answer strobe |
| card_resp_count | input | RCNT_W (5) | Answer length in bytes |
| card_resp_bytes | input | 8*RESP_MAX_BYTES (128) | Answer bytes, byte k at bits 8k+7:8k |
| fifo_req_set | input | 2 | Data-FIFO request set pulses (bit 0 RX, bit 1 TX) |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | DMA receive request |
| dma_tx_req | output | 1 | DMA transmit request |
| xfer_active | output | 1 | Data transfer armed after the command |
| data_bytes_left | output | BLK_W+NUM_W (28) | Loaded data byte counter |

## Verification
The bench uses the default parameters: nine FIFO entries, a 16-byte answer limit, a 12-bit block length, a 16-bit block count and DMA routing built in. With these values, the nine FIFO entries can hold the full 16-byte answer and still have one spare entry, so both the always-zero ninth entry and the zero returned past the end are checked. The behavioural card answers with 0, 4 or 16 bytes, which covers every response type at and below its threshold. The DMA routing variant is built, so the bench can check that the request bits move from `irq` to the DMA outputs.

// File: rtl/sdmmc_cmd_pkg.sv
package sdmmc_cmd_pkg;
   // register word addresses
   localparam int RA_CLK    = 0;
   localparam int RA_STAT   = 1;
   localparam int RA_CTRL   = 2;
   localparam int RA_BLKLEN = 3;
   localparam int RA_NUMBLK = 4;
   localparam int RA_MASK   = 5;
   localparam int RA_PEND   = 6;
   localparam int RA_INDEX  = 7;
   localparam int RA_ARGH   = 8;
   localparam int RA_ARGL   = 9;
   localparam int RA_RESP   = 10;
   localparam int RA_BYTES  = 11;

   // status bits
   localparam int ST_TOUT   = 1;
   localparam int ST_CLK    = 8;
   localparam int ST_RESPOK = 13;
   // control word bits
   localparam int CT_DATA   = 2;
   localparam int CT_DMA    = 7;
   localparam int CT_STOP   = 10;
   localparam logic [15:0] CTRL_KEEP = 16'h3dff;
   // pending bits
   localparam int PD_END    = 2;
   localparam int PD_CLKOFF = 4;
   localparam int PD_RXREQ  = 5;
   localparam int PD_TXREQ  = 6;
   localparam int PEND_W    = 13;

   typedef enum logic {SQ_IDLE, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/sdmmc_resp_check.sv
module sdmmc_resp_check #(
   parameter int RCNT_W    = 5,
   parameter int SHORT_MIN = 4,
   parameter int LONG_MIN  = 16
) (
   input  logic [1:0]        rtype,
   input  logic [RCNT_W-1:0] count,
   output logic              ok
);
   logic [31:0] need;
   always_comb begin
      unique case (rtype)
         2'd0:    need = 32'd0;
         2'd2:    need = 32'(LONG_MIN);
         default: need = 32'(SHORT_MIN);
      endcase
      ok = 32'(count) >= need;
   end
endmodule

// File: rtl/sdmmc_resp_fifo.sv
module sdmmc_resp_fifo #(
   parameter int ENTRIES   = 9,
   parameter int MAX_BYTES = 16,
   parameter int RCNT_W    = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   load,
   input  logic [RCNT_W-1:0]      count,
   input  logic [8*MAX_BYTES-1:0] bytes,
   input  logic                   pop,
   output logic [15:0]            head
);
   localparam int PTR_W = $clog2(ENTRIES + 1);

   logic [15:0]      ent [ENTRIES];
   logic [PTR_W-1:0] ptr;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [7:0] lo_b, hi_b;
      if (2*e < MAX_BYTES) begin : g_lo
         assign lo_b = (32'(count) > 2*e) ? bytes[16*e +: 8] : 8'h00;
      end else begin : g_lo_none
         assign lo_b = 8'h00;
      end
      if (2*e+1 < MAX_BYTES) begin : g_hi
         assign hi_b = (32'(count) > 2*e+1) ? bytes[16*e+8 +: 8] : 8'h00;
      end else begin : g_hi_none
         assign hi_b = 8'h00;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ent[e] <= '0;
         else if (clear)  ent[e] <= '0;
         else if (load)   ent[e] <= {hi_b, lo_b};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ptr <= '0;
      else if (clear)                            ptr <= '0;
      else if (pop && 32'(ptr) < ENTRIES)        ptr <= ptr + 1'b1;
   end

   assign head = (32'(ptr) < ENTRIES) ? ent[ptr] : 16'h0000;
endmodule

// File: rtl/sdmmc_irq_ctrl.sv
module sdmmc_irq_ctrl #(
   parameter int NBITS     = 13,
   parameter bit DMA_ROUTE = 1'b1,
   parameter int RX_BIT    = 5,
   parameter int TX_BIT    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_bits,
   input  logic [NBITS-1:0] clr_bits,
   input  logic             mask_we,
   input  logic [NBITS-1:0] mask_wdata,
   input  logic             dma_en,
   output logic [NBITS-1:0] pend,
   output logic [NBITS-1:0] mask,
   output logic             irq,
   output logic             dma_rx,
   output logic             dma_tx
);
   logic [NBITS-1:0] route_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         mask <= '0;
      end else begin
         pend <= (pend & ~clr_bits) | set_bits;
         if (mask_we) mask <= mask_wdata;
      end
   end

   if (DMA_ROUTE) begin : g_dma
      always_comb begin
         route_mask = '0;
         route_mask[RX_BIT] = dma_en;
         route_mask[TX_BIT] = dma_en;
      end
      assign dma_rx = dma_en & pend[RX_BIT];
      assign dma_tx = dma_en & pend[TX_BIT];
   end else begin : g_nodma
      assign route_mask = '0;
      assign dma_rx = 1'b0;
      assign dma_tx = 1'b0;
   end

   assign irq = |(pend & ~(mask | route_mask));
endmodule

// File: rtl/sdmmc_cmd_seq.sv
module sdmmc_cmd_seq
   import sdmmc_cmd_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int BLK_W          = 12,
   parameter int NUM_W          = 16,
   parameter int RESP_ENTRIES   = 9,
   parameter int RESP_MAX_BYTES = 16,
   parameter int RCNT_W         = $clog2(RESP_MAX_BYTES + 1),
   parameter bit DMA_ROUTE      = 1'b1,
   localparam int CNT_W         = BLK_W + NUM_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   output logic                        card_cmd_valid,
   output logic [5:0]                  card_cmd_index,
   output logic [31:0]                 card_cmd_arg,
   input  logic                        card_resp_valid,
   input  logic [RCNT_W-1:0]           card_resp_count,
   input  logic [8*RESP_MAX_BYTES-1:0] card_resp_bytes,
   input  logic [1:0]                  fifo_req_set,
   output logic                        irq,
   output logic                        dma_rx_req,
   output logic                        dma_tx_req,
   output logic                        xfer_active,
   output logic [CNT_W-1:0]            data_bytes_left
);
   // elaboration-time parameter checks
   if (ADDR_W < 4)                          begin : g_bad_addr $fatal(1, "ADDR_W too small"); end
   if (2*RESP_ENTRIES < RESP_MAX_BYTES)     begin : g_bad_fifo $fatal(1, "FIFO too shallow"); end
   if (RESP_MAX_BYTES < 16)                 begin : g_bad_max  $fatal(1, "long answer needs 16 bytes"); end
   if (CNT_W > 32)                          begin : g_bad_cnt  $fatal(1, "byte counter too wide"); end
   if ((1 << RCNT_W) <= RESP_MAX_BYTES)     begin : g_bad_rcnt $fatal(1, "RCNT_W too small"); end

   localparam logic [ADDR_W-1:0] A_CLK    = ADDR_W'(RA_CLK);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(RA_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] A_BLKLEN = ADDR_W'(RA_BLKLEN);
   localparam logic [ADDR_W-1:0] A_NUMBLK = ADDR_W'(RA_NUMBLK);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(RA_MASK);
   localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(RA_PEND);
   localparam logic [ADDR_W-1:0] A_INDEX  = ADDR_W'(RA_INDEX);
   localparam logic [ADDR_W-1:0] A_ARGH   = ADDR_W'(RA_ARGH);
   localparam logic [ADDR_W-1:0] A_ARGL   = ADDR_W'(RA_ARGL);
   localparam logic [ADDR_W-1:0] A_RESP   = ADDR_W'(RA_RESP);
   localparam logic [ADDR_W-1:0] A_BYTES  = ADDR_W'(RA_BYTES);

   // architectural state
   seq_state_e          state_q;
   logic [15:0]         status_q, status_d;
   logic [15:0]         ctrl_q;
   logic [BLK_W-1:0]    blklen_q;
   logic [NUM_W-1:0]    numblk_q;
   logic [5:0]          index_q;
   logic [31:0]         arg_q;
   logic                armed_q, active_q, cmd_valid_q;
   logic [CNT_W-1:0]    bytes_q;

   // decode
   logic wr_clk, wr_ctrl, clk_start, clk_stop;
   logic issue_ctrl, issue_clk, issue_go, resp_take, resp_ok, clk_running;
   logic fifo_pop;
   logic [15:0] fifo_head;
   logic [PEND_W-1:0] pend, mask, pend_set, pend_clr;

   assign wr_clk      = reg_wr && (reg_addr == A_CLK);
   assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
   assign clk_start   = wr_clk && reg_wdata[1];
   assign clk_stop    = wr_clk && reg_wdata[0];
   assign clk_running = status_q[ST_CLK];

   assign issue_ctrl  = wr_ctrl && !reg_wdata[CT_STOP] && clk_running;
   assign issue_clk   = clk_start && !clk_stop && armed_q && !ctrl_q[CT_STOP];
   assign issue_go    = issue_ctrl || issue_clk;
   assign resp_take   = (state_q == SQ_WAIT) && card_resp_valid && !wr_ctrl && !clk_stop;
   assign fifo_pop    = reg_rd && (reg_addr == A_RESP);

   sdmmc_resp_check #(
      .RCNT_W(RCNT_W), .SHORT_MIN(4), .LONG_MIN(16)
   ) u_check (
      .rtype(ctrl_q[1:0]), .count(card_resp_count), .ok(resp_ok)
   );

   sdmmc_resp_fifo #(
      .ENTRIES(RESP_ENTRIES), .MAX_BYTES(RESP_MAX_BYTES), .RCNT_W(RCNT_W)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .clear(issue_go), .load(resp_take && resp_ok),
      .count(card_resp_count), .bytes(card_resp_bytes),
      .pop(fifo_pop), .head(fifo_head)
   );

   always_comb begin
      pend_set = '0;
      pend_set[PD_END]    = resp_take;
      pend_set[PD_CLKOFF] = clk_stop;
      pend_set[PD_RXREQ]  = fifo_req_set[0];
      pend_set[PD_TXREQ]  = fifo_req_set[1];
      pend_clr = '0;
      if (reg_wr && reg_addr == A_PEND) pend_clr = reg_wdata[PEND_W-1:0];
      if (clk_start)                    pend_clr[PD_CLKOFF] = 1'b1;
   end

   sdmmc_irq_ctrl #(
      .NBITS(PEND_W), .DMA_ROUTE(DMA_ROUTE), .RX_BIT(PD_RXREQ), .TX_BIT(PD_TXREQ)
   ) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_bits(pend_set), .clr_bits(pend_clr),
      .mask_we(reg_wr && reg_addr == A_MASK), .mask_wdata(reg_wdata[PEND_W-1:0]),
      .dma_en(ctrl_q[CT_DMA]),
      .pend(pend), .mask(mask), .irq(irq), .dma_rx(dma_rx_req), .dma_tx(dma_tx_req)
   );

   // status next state
   always_comb begin
      status_d = status_q;
      if (resp_take) begin
         if (resp_ok) status_d[ST_RESPOK] = 1'b1;
         else         status_d[ST_TOUT]   = 1'b1;
      end
      if ((wr_ctrl && !reg_wdata[CT_STOP]) || issue_clk)
         status_d = status_d & (16'h1 << ST_CLK);
      if (clk_start) status_d[ST_CLK] = 1'b1;
      if (clk_stop)  status_d[ST_CLK] = 1'b0;
   end

   // sequencer and configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         status_q    <= '0;
         ctrl_q      <= '0;
         blklen_q    <= '0;
         numblk_q    <= '0;
         index_q     <= '0;
         arg_q       <= '0;
         armed_q     <= 1'b0;
         active_q    <= 1'b0;
         cmd_valid_q <= 1'b0;
         bytes_q     <= '0;
      end else begin
         status_q    <= status_d;
         cmd_valid_q <= issue_go;

         if (clk_stop)       state_q <= SQ_IDLE;
         else if (issue_go)  state_q <= SQ_WAIT;
         else if (resp_take) state_q <= SQ_IDLE;
         else if (wr_ctrl)   state_q <= SQ_IDLE;

         if (issue_go)     armed_q <= 1'b0;
         else if (wr_ctrl) armed_q <= 1'b1;

         if (resp_take && resp_ok && ctrl_q[CT_DATA]) begin
            active_q <= 1'b1;
            bytes_q  <= CNT_W'(blklen_q) * CNT_W'(numblk_q);
         end
         if (wr_ctrl || clk_stop) active_q <= 1'b0;

         if (reg_wr) begin
            unique case (reg_addr)
               A_CTRL:   ctrl_q   <= reg_wdata[15:0] & CTRL_KEEP;
               A_BLKLEN: blklen_q <= reg_wdata[BLK_W-1:0];
               A_NUMBLK: numblk_q <= reg_wdata[NUM_W-1:0];
               A_INDEX:  index_q  <= reg_wdata[5:0];
               A_ARGH:   arg_q[31:16] <= reg_wdata[15:0];
               A_ARGL:   arg_q[15:0]  <= reg_wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_rdata <= '0;
      else if (reg_rd) begin
         unique case (reg_addr)
            A_STAT:   reg_rdata <= {16'h0, status_q};
            A_CTRL:   reg_rdata <= {16'h0, ctrl_q};
            A_BLKLEN: reg_rdata <= 32'(blklen_q);
            A_NUMBLK: reg_rdata <= 32'(numblk_q);
            A_MASK:   reg_rdata <= 32'(mask);
            A_PEND:   reg_rdata <= 32'(pend);
            A_INDEX:  reg_rdata <= {25'h0, 1'b1, index_q};
            A_ARGH:   reg_rdata <= {16'h0, arg_q[31:16]};
            A_ARGL:   reg_rdata <= {16'h0, arg_q[15:0]};
            A_RESP:   reg_rdata <= {16'h0, fifo_head};
            A_BYTES:  reg_rdata <= 32'(bytes_q);
            default:  reg_rdata <= '0;
         endcase
      end
   end

   assign card_cmd_valid  = cmd_valid_q;
   assign card_cmd_index  = index_q;
   assign card_cmd_arg    = arg_q;
   assign xfer_active     = active_q;
   assign data_bytes_left = bytes_q;
endmodule

// File: rtl/sdmmc_cmd_seq_chk.sv
module sdmmc_cmd_seq_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              card_cmd_valid,
   input logic              xfer_active,
   input logic              clk_running
);
   logic wr_ctrl, wr_stop;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(2));
   assign wr_stop = reg_wr && (reg_addr == ADDR_W'(0)) && reg_wdata[0];

   AST_ISSUE_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      card_cmd_valid |-> clk_running); // R5
   AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stop |=> (!xfer_active && !clk_running)); // R9
   AST_CTRL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !xfer_active); // R4
   AST_STOP_TRANSFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[10]) |=> !card_cmd_valid); // R4
endmodule

bind sdmmc_cmd_seq sdmmc_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .card_cmd_valid(card_cmd_valid),
   .xfer_active(xfer_active), .clk_running(clk_running)
);

// File: tb/sdmmc_cmd_seq_test.sv
module sdmmc_cmd_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // each entry: response type * 32 + bytes returned by the card
   localparam int VT [NVEC] = '{0*32+0, 1*32+4, 1*32+0, 2*32+16, 2*32+4, 3*32+4, 3*32+0};

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic card_cmd_valid;
   logic [5:0] card_cmd_index;
   logic [31:0] card_cmd_arg;
   logic card_resp_valid = 1'b0;
   logic [4:0] card_len = '0;
   logic [127:0] card_bytes;
   logic [1:0] fifo_req_set = '0;
   logic irq, dma_rx_req, dma_tx_req, xfer_active;
   logic [27:0] data_bytes_left;

   int checks = 0, errors = 0, cmd_count = 0, dly = 0;
   logic [5:0] seen_idx;
   logic [31:0] seen_arg;
   logic [31:0] rv, rv2;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar k = 0; k < 16; k++) begin : g_bytes
      assign card_bytes[8*k +: 8] = 8'hA0 + 8'(k);
   end

   sdmmc_cmd_seq uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .card_cmd_valid(card_cmd_valid), .card_cmd_index(card_cmd_index),
      .card_cmd_arg(card_cmd_arg), .card_resp_valid(card_resp_valid),
      .card_resp_count(card_len), .card_resp_bytes(card_bytes),
      .fifo_req_set(fifo_req_set), .irq(irq), .dma_rx_req(dma_rx_req),
      .dma_tx_req(dma_tx_req), .xfer_active(xfer_active),
      .data_bytes_left(data_bytes_left)
   );

   // behavioural card: answers three cycles after the command pulse
   always @(posedge clk) begin
      if (card_resp_valid) card_resp_valid <= 1'b0;
      if (card_cmd_valid) begin
         cmd_count <= cmd_count + 1;
         seen_idx  <= card_cmd_index;
         seen_arg  <= card_cmd_arg;
         dly       <= 2;
      end else if (dly != 0) begin
         dly <= dly - 1;
         if (dly == 1) card_resp_valid <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 4'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic run_cmd(input logic [31:0] ctrl);
      wr(2, ctrl);
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [1:0] v);
      @(negedge clk); fifo_req_set = v;
      @(negedge clk); fifo_req_set = 2'b00;
   endtask

   function automatic logic [15:0] exp_entry(input int rtype, input int len, input int i);
      logic ok;
      logic [7:0] lo, hi;
      ok = (rtype == 0) || (rtype == 2 ? len >= 16 : len >= 4);
      lo = (ok && 2*i < len)   ? 8'(8'hA0 + 2*i)     : 8'h00;
      hi = (ok && 2*i+1 < len) ? 8'(8'hA0 + 2*i + 1) : 8'h00;
      return {hi, lo};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R1)
      check("R1 irq after reset", 32'(irq), 0);
      check("R13 cmd_valid after reset", 32'(card_cmd_valid), 0);
      rd(1, rv); check("R1 status after reset", rv, 0);
      rd(6, rv); check("R1 pending after reset", rv, 0);
      rd(0, rv); check("R1 clock control reads 0", rv, 0);
      // R9 start clock
      wr(0, 2);
      rd(1, rv); check("R9 start sets clock bit", rv, 32'h100);
      // R2 index
      wr(7, 32'h7F); rd(7, rv); check("R2 index 6 bits", rv, 32'h7F);
      wr(7, 32'h25); rd(7, rv); check("R2 index with bit6", rv, 32'h65);
      // R3 argument halves
      wr(8, 32'hFFFF1234); wr(9, 32'h0000ABCD);
      rd(8, rv); check("R3 arg high", rv, 32'h1234);
      rd(9, rv); check("R3 arg low", rv, 32'hABCD);
      wr(9, 32'h5555); rd(8, rv); check("R3 high kept", rv, 32'h1234);
      // R4 control mask, stop-transfer blocks issue
      c0 = cmd_count;
      wr(2, 32'hFFFFFFFF); repeat (6) @(negedge clk);
      rd(2, rv); check("R4 control mask", rv, 32'h3DFF);
      check("R4 stop-transfer no issue", 32'(cmd_count), 32'(c0));

      // R6 R7 R8 response type table
      for (int v = 0; v < NVEC; v++) begin
         int rt, ln;
         logic ok;
         rt = VT[v] / 32; ln = VT[v] % 32;
         ok = (rt == 0) || (rt == 2 ? ln >= 16 : ln >= 4);
         wr(6, 32'h1FFF);
         card_len = 5'(ln);
         c0 = cmd_count;
         run_cmd(32'(rt));
         check("R13 one issue per command", 32'(cmd_count), 32'(c0 + 1));
         rd(1, rv); check("R6 status", rv, ok ? 32'h2100 : 32'h0102);
         rd(6, rv); check("R8 end-of-command pending", rv, 32'h4);
         for (int i = 0; i < 9; i++) begin
            rd(10, rv); check("R7 fifo entry", rv, 32'(exp_entry(rt, ln, i)));
         end
         rd(10, rv); check("R7 read past end", rv, 0);
      end
      check("R13 index to card", 32'(seen_idx), 32'h25);
      check("R13 argument to card", seen_arg, 32'h12345555);

      // R8 byte counter
      wr(3, 3); wr(4, 5); card_len = 5'd4;
      run_cmd(32'h5);
      check("R8 byte counter", 32'(data_bytes_left), 15);
      check("R8 active", 32'(xfer_active), 1);
      rd(11, rv); check("R1 byte counter read", rv, 15);
      // R9 stop clock
      wr(0, 1);
      check("R9 stop aborts", 32'(xfer_active), 0);
      rd(1, rv); check("R9 clock bit cleared", rv & 32'h100, 0);
      rd(6, rv); check("R9 clock-off pending", rv & 32'h10, 32'h10);
      // R5 armed while stopped
      c0 = cmd_count;
      run_cmd(32'h1);
      check("R5 no issue while stopped", 32'(cmd_count), 32'(c0));
      wr(0, 2); repeat (8) @(negedge clk);
      check("R5 issue on start", 32'(cmd_count), 32'(c0 + 1));
      rd(6, rv); check("R9 start clears clock-off", rv & 32'h10, 0);
      c0 = cmd_count;
      run_cmd(32'h401);
      wr(0, 2); repeat (8) @(negedge clk);
      check("R5 stop-transfer blocks start issue", 32'(cmd_count), 32'(c0));
      // R10 mask and R12 write-1-to-clear
      wr(5, 32'h1FFF); wr(6, 32'h1FFF);
      run_cmd(32'h1);
      check("R10 masked irq", 32'(irq), 0);
      rd(1, rv); rd(1, rv2); check("R12 status read no effect", rv2, rv);
      wr(5, 32'h1FFB);
      check("R10 unmasked irq", 32'(irq), 1);
      wr(6, 32'h4);
      check("R12 w1c drops irq", 32'(irq), 0);
      rd(6, rv); check("R12 pending cleared", rv, 0);
      // R11 DMA routing
      wr(5, 0);
      pulse_req(2'b01);
      check("R11 rx to irq without dma", 32'(irq), 1);
      check("R11 no dma request", 32'(dma_rx_req), 0);
      wr(6, 32'h1FFF);
      wr(2, 32'h481);
      pulse_req(2'b11);
      check("R11 dma hides from irq", 32'(irq), 0);
      check("R11 dma rx request", 32'(dma_rx_req), 1);
      check("R11 dma tx request", 32'(dma_tx_req), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule